// File: doc/BRIEF.md
# I2C Target Address Front End with Strap-Selected Address

This block is the bus-facing front end of an I2C target. It runs on a system clock that is much faster than SCL. Both bus lines pass through multi-flop synchronizers, and all detection and shifting works on the synchronized samples. The block recognizes START, repeated START and STOP conditions and shifts in the address byte MSB first. It compares the seven address bits with a pattern in which fixed bits alternate with three strap inputs, so one design can answer at one of eight addresses.

When the address matches, the block pulls SDA low for the acknowledge clock and latches the direction bit. It then moves whole bytes through a byte-wide port toward the rest of the target. In write direction each received byte is presented with a one-cycle strobe and is acknowledged. In read direction the block takes the byte offered on `tx_data_i` at the end of each acknowledge clock and signals the take with a one-cycle pulse. It shifts that byte out MSB first and keeps going for as long as the controller acknowledges.

A START that opens an address phase is not interrupted by later bus conditions. Any START or STOP seen before the address has been acknowledged is ignored.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset, `sda_oe_o`, `sel_o`, `rd_mode_o`, `rx_valid_o`, `tx_pop_o` and `nack_o` are all 0.
- R2: The target address, bit 6 down to bit 0, is 1, 0, strap[2], 0, strap[1], 0, strap[0]. A matching address byte is acknowledged: SDA is held low while SCL is high on the ninth clock, and `sel_o` is 1 from then on.
- R3: An address byte that differs from the pattern in any bit, fixed or strapped, gets no acknowledge. In that case `sel_o` stays 0, SDA stays released for any further clocks, and no byte is reported, until the next START or STOP.
- R4: Bit 0 of the address byte sets the direction. `rd_mode_o` is 1 after a matching byte whose bit 0 is 1 (the target sends), and 0 after one whose bit 0 is 0 (the controller writes).
- R5: In write direction each data byte is taken MSB first from clocks 1 to 8. After the eighth bit, `rx_valid_o` pulses for one cycle with the byte on `rx_data_o`, and the byte is acknowledged on clock 9.
- R6: In read direction the byte on `tx_data_i` is captured at the falling SCL edge that ends each acknowledge clock. `tx_pop_o` pulses for one cycle at that capture. The byte is placed on SDA MSB first, and each bit is stable while SCL is high.
- R7: A controller acknowledge (SDA low on clock 9) after a read byte causes the next byte to be taken. A NACK (SDA high) causes a one-cycle `nack_o` pulse, SDA stays released, and no further byte is taken until the next START or STOP.
- R8: A STOP after an acknowledged address returns the block to idle, with `sel_o` and `rd_mode_o` set to 0.
- R9: A repeated START after an acknowledged address starts a new address phase. A new matching address is acknowledged, and its direction bit replaces the previous one.
- R10: A STOP or START pattern on the bus after a START and before that START's address has been acknowledged is ignored. The address bits keep being shifted, and a matching address is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | N_STRAP | Address strap inputs (bit 0 sets address bit 0) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_o | output | 1 | Target is addressed (from acknowledge to STOP or new START) |
| rd_mode_o | output | 1 | Direction flag: 1 means the target sends |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received data byte |
| tx_pop_o | output | 1 | One-cycle pulse: the byte on tx_data_i was taken |
| tx_data_i | input | 8 | Next byte to send; must be valid before it is taken |
| nack_o | output | 1 | One-cycle pulse when the controller NACKs a read byte |

## Verification
Address matching is tried with the strapped address and with two near misses. One miss flips only a strap-controlled bit and the other flips only a fixed bit, which separates a faulty strap mapping from a faulty fixed pattern. A second strap setting confirms that the pattern follows the pins. The transfer tests cover write bursts, a read burst ended by a NACK, and a write followed by a repeated START into a read; together they separate direction handling, the controller-acknowledge path and mid-transfer condition detection. One address is sent with a STOP pattern embedded in a bit, which shows whether conditions are gated until the acknowledge.

// File: rtl/i2c_strap_pkg.sv
`timescale 1ns/1ps
package i2c_strap_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [3:0] {
      TS_IDLE,    // waiting for START
      TS_ADDR,    // shifting the address byte
      TS_AACK,    // driving the address acknowledge
      TS_WDAT,    // receiving a data byte
      TS_WACK,    // driving a data acknowledge
      TS_RDAT,    // sending a data byte
      TS_RACK,    // sampling the controller acknowledge
      TS_RDONE,   // read ended by NACK, waiting for a condition
      TS_SKIP     // not addressed, waiting for a condition
   } tgt_state_t;

   // position of address bit 'bit_idx' among the strap-controlled bits
   function automatic int strap_rank(input logic [ADDR_W-1:0] mask, input int bit_idx);
      int r;
      r = 0;
      for (int k = 0; k < ADDR_W; k++) begin
         if (k < bit_idx && mask[k]) r++;
      end
      return r;
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl_o,
   output logic sda_lvl_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_prev;
   logic              sda_prev;

   // bus lines idle high, so every flop resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_prev  <= 1'b1;
         sda_prev  <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[STAGES-2:0], sda_i};
         scl_prev  <= scl_chain[STAGES-1];
         sda_prev  <= sda_chain[STAGES-1];
      end
   end

   assign scl_lvl_o  = scl_chain[STAGES-1];
   assign sda_lvl_o  = sda_chain[STAGES-1];
   assign scl_rise_o = scl_lvl_o & ~scl_prev;
   assign scl_fall_o = ~scl_lvl_o & scl_prev;
   // a data edge counts as a condition only while the clock stays high
   assign start_o    = scl_lvl_o & scl_prev & sda_prev & ~sda_lvl_o;
   assign stop_o     = scl_lvl_o & scl_prev & ~sda_prev & sda_lvl_o;

endmodule

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match
   import i2c_strap_pkg::*;
#(
   parameter int                N_STRAP    = 3,
   parameter logic [ADDR_W-1:0] FIXED_BITS = 7'b1000000,
   parameter logic [ADDR_W-1:0] STRAP_MASK = 7'b0010101
) (
   input  logic [N_STRAP-1:0] strap_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic               hit_o
);

   if ($countones(STRAP_MASK) != N_STRAP) begin : g_bad_mask
      $error("i2c_addr_match: STRAP_MASK must have N_STRAP ones");
   end
   if ((FIXED_BITS & STRAP_MASK) != '0) begin : g_bad_fixed
      $error("i2c_addr_match: FIXED_BITS overlaps STRAP_MASK");
   end

   logic [ADDR_W-1:0] pattern;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (STRAP_MASK[b]) begin : g_strap
         assign pattern[b] = strap_i[strap_rank(STRAP_MASK, b)];
      end else begin : g_fixed
         assign pattern[b] = FIXED_BITS[b];
      end
   end

   assign hit_o = (addr_i == pattern);

endmodule

// File: rtl/i2c_strap_target.sv
`timescale 1ns/1ps
module i2c_strap_target
   import i2c_strap_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                N_STRAP     = 3,
   parameter logic [ADDR_W-1:0] FIXED_BITS  = 7'b1000000,
   parameter logic [ADDR_W-1:0] STRAP_MASK  = 7'b0010101
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [N_STRAP-1:0] strap_i,
   output logic               sda_oe_o,
   output logic               sel_o,
   output logic               rd_mode_o,
   output logic               rx_valid_o,
   output logic [BYTE_W-1:0]  rx_data_o,
   output logic               tx_pop_o,
   input  logic [BYTE_W-1:0]  tx_data_i,
   output logic               nack_o
);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, cond_start, cond_stop;
   logic addr_hit;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_lvl_o  (scl_lvl),
      .sda_lvl_o  (sda_lvl),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (cond_start),
      .stop_o     (cond_stop)
   );

   tgt_state_t        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              hi_seen;
   logic              ctl_nak;
   logic              oe_q, sel_q, rd_q, rxv_q, pop_q, nck_q;
   logic [BYTE_W-1:0] rxd_q;

   i2c_addr_match #(
      .N_STRAP    (N_STRAP),
      .FIXED_BITS (FIXED_BITS),
      .STRAP_MASK (STRAP_MASK)
   ) u_match (
      .strap_i (strap_i),
      .addr_i  (shreg[BYTE_W-1:1]),
      .hit_o   (addr_hit)
   );

   // conditions are honoured only outside the address phase and its acknowledge
   logic cond_ok;
   assign cond_ok = (state != TS_ADDR) && (state != TS_AACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TS_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         hi_seen <= 1'b0;
         ctl_nak <= 1'b0;
         oe_q    <= 1'b0;
         sel_q   <= 1'b0;
         rd_q    <= 1'b0;
         rxv_q   <= 1'b0;
         pop_q   <= 1'b0;
         nck_q   <= 1'b0;
         rxd_q   <= '0;
      end else begin
         rxv_q <= 1'b0;
         pop_q <= 1'b0;
         nck_q <= 1'b0;
         if (cond_ok && cond_start) begin
            state   <= TS_ADDR;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
            sel_q   <= 1'b0;
            rd_q    <= 1'b0;
         end else if (cond_ok && cond_stop && state != TS_IDLE) begin
            state   <= TS_IDLE;
            oe_q    <= 1'b0;
            sel_q   <= 1'b0;
            rd_q    <= 1'b0;
         end else begin
            unique case (state)
               TS_IDLE, TS_RDONE, TS_SKIP: ;
               TS_ADDR: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                     if (addr_hit) begin
                        state   <= TS_AACK;
                        oe_q    <= 1'b1;
                        sel_q   <= 1'b1;
                        rd_q    <= shreg[0];
                        hi_seen <= 1'b0;
                     end else begin
                        state <= TS_SKIP;
                     end
                  end
               end
               TS_AACK, TS_WACK: begin
                  if (scl_rise) begin
                     hi_seen <= 1'b1;
                  end else if (scl_fall && hi_seen) begin
                     hi_seen <= 1'b0;
                     bit_cnt <= '0;
                     if (state == TS_AACK && rd_q) begin
                        shreg <= tx_data_i;
                        pop_q <= 1'b1;
                        oe_q  <= ~tx_data_i[BYTE_W-1];
                        state <= TS_RDAT;
                     end else begin
                        oe_q  <= 1'b0;
                        state <= TS_WDAT;
                     end
                  end
               end
               TS_WDAT: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                     rxd_q   <= shreg;
                     rxv_q   <= 1'b1;
                     oe_q    <= 1'b1;
                     hi_seen <= 1'b0;
                     state   <= TS_WACK;
                  end
               end
               TS_RDAT: begin
                  if (scl_fall) begin
                     if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        oe_q    <= 1'b0;
                        hi_seen <= 1'b0;
                        state   <= TS_RACK;
                     end else begin
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        oe_q    <= ~shreg[BYTE_W-2];
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               TS_RACK: begin
                  if (scl_rise) begin
                     hi_seen <= 1'b1;
                     ctl_nak <= sda_lvl;
                  end else if (scl_fall && hi_seen) begin
                     hi_seen <= 1'b0;
                     if (ctl_nak) begin
                        nck_q <= 1'b1;
                        state <= TS_RDONE;
                     end else begin
                        shreg   <= tx_data_i;
                        pop_q   <= 1'b1;
                        oe_q    <= ~tx_data_i[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= TS_RDAT;
                     end
                  end
               end
               default: state <= TS_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o   = oe_q;
   assign sel_o      = sel_q;
   assign rd_mode_o  = rd_q;
   assign rx_valid_o = rxv_q;
   assign rx_data_o  = rxd_q;
   assign tx_pop_o   = pop_q;
   assign nack_o     = nck_q;

endmodule

// File: rtl/i2c_strap_target_chk.sv
`timescale 1ns/1ps
module i2c_strap_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic sda_oe_o,
   input logic sel_o,
   input logic rd_mode_o,
   input logic rx_valid_o,
   input logic tx_pop_o,
   input logic nack_o
);

   // R3: the line is only ever pulled while the target is addressed
   p_oe_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> sel_o);

   // R4: received bytes only arrive in write direction
   p_rx_write_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> !rd_mode_o);

   // R5: receive strobe lasts one cycle
   p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R6: bytes are only taken in read direction
   p_pop_read_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop_o |-> (rd_mode_o && sel_o));

   // R6: the drive on SDA never changes while the synchronized clock is high
   p_sda_change_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_lvl);

   // R7: a controller NACK leaves the line released and takes no byte
   p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nack_o |-> (!sda_oe_o && !tx_pop_o));

endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_lvl    (scl_lvl),
   .sda_oe_o   (sda_oe_o),
   .sel_o      (sel_o),
   .rd_mode_o  (rd_mode_o),
   .rx_valid_o (rx_valid_o),
   .tx_pop_o   (tx_pop_o),
   .nack_o     (nack_o)
);

// File: tb/i2c_strap_target_bench.sv
`timescale 1ns/1ps
module i2c_strap_target_bench;

   localparam time Q = 200ns;   // quarter of an SCL period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_ctl = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       sda_oe, sel, rd_mode, rx_valid, tx_pop, nack;
   logic [7:0] rx_data, tx_data;
   logic       sda_bus;

   int n_chk = 0, n_bad = 0;
   int tx_k = 0, pop_cnt = 0, nack_cnt = 0;
   logic [7:0] exp_rx[$];
   bit done = 0;

   always #5ns clk = ~clk;

   assign sda_bus = sda_ctl & ~sda_oe;
   assign tx_data = 8'h3C + 8'(tx_k * 17);

   i2c_strap_target u_i2c_strap_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .strap_i    (strap),
      .sda_oe_o   (sda_oe),
      .sel_o      (sel),
      .rd_mode_o  (rd_mode),
      .rx_valid_o (rx_valid),
      .rx_data_o  (rx_data),
      .tx_pop_o   (tx_pop),
      .tx_data_i  (tx_data),
      .nack_o     (nack)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected received bytes and counts pulses
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            if (exp_rx.size() == 0) chk(0, "R3/R5 unexpected byte", rx_data, 0);
            else begin
               logic [7:0] e;
               e = exp_rx.pop_front();
               chk(rx_data == e, "R5 received byte", rx_data, e);
            end
         end
         if (tx_pop) begin
            tx_k++;
            pop_cnt++;
         end
         if (nack) nack_cnt++;
      end
   end

   task automatic bus_start();
      sda_ctl = 1'b0; #Q; scl = 1'b0; #Q;
   endtask
   task automatic bus_rstart();
      sda_ctl = 1'b1; #Q; scl = 1'b1; #Q; sda_ctl = 1'b0; #Q; scl = 1'b0; #Q;
   endtask
   task automatic bus_stop();
      sda_ctl = 1'b0; #Q; scl = 1'b1; #Q; sda_ctl = 1'b1; #Q;
   endtask
   task automatic clk_bit(input logic b, output logic s);
      sda_ctl = b; #Q; scl = 1'b1; #Q; s = sda_bus; #Q; scl = 1'b0; #Q;
   endtask
   task automatic send_byte(input logic [7:0] d, output bit acked);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
      clk_bit(1'b1, s);
      acked = !s;
   endtask
   task automatic recv_byte(input bit last, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(last, s);
   endtask

   initial begin
      bit ack;
      logic [7:0] d;
      logic [7:0] e;
      int k;
      #50ns;
      chk(sda_oe == 0 && sel == 0 && rd_mode == 0 && rx_valid == 0 && tx_pop == 0 && nack == 0,
          "R1 reset outputs", {sda_oe, sel, rd_mode, rx_valid, tx_pop, nack}, 0);
      rst_n = 1'b1;
      #100ns;

      // write to strapped address 0x51
      bus_start();
      send_byte({7'h51, 1'b0}, ack);
      chk(ack, "R2 address ack", ack, 1);
      chk(sel == 1, "R2 selected", sel, 1);
      chk(rd_mode == 0, "R4 write direction", rd_mode, 0);
      exp_rx.push_back(8'hA5);
      send_byte(8'hA5, ack);
      chk(ack, "R5 data ack", ack, 1);
      exp_rx.push_back(8'h3C);
      send_byte(8'h3C, ack);
      chk(ack, "R5 data ack 2", ack, 1);
      bus_stop();
      #100ns;
      chk(sel == 0, "R8 stop deselects", sel, 0);

      // mismatch on a strapped bit, then a data byte
      bus_start();
      send_byte({7'h50, 1'b0}, ack);
      chk(!ack, "R3 strap-bit mismatch no ack", ack, 0);
      send_byte(8'h00, ack);
      chk(!ack, "R3 released after mismatch", ack, 0);
      chk(sel == 0, "R3 not selected", sel, 0);
      bus_stop();
      #100ns;

      // mismatch on a fixed bit
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      chk(!ack, "R3 fixed-bit mismatch no ack", ack, 0);
      bus_stop();
      #100ns;

      // read burst: ack one byte, nack the next
      pop_cnt = 0; nack_cnt = 0;
      k = tx_k;
      bus_start();
      send_byte({7'h51, 1'b1}, ack);
      chk(ack, "R2 read address ack", ack, 1);
      chk(rd_mode == 1, "R4 read direction", rd_mode, 1);
      recv_byte(1'b0, d);
      e = 8'h3C + 8'(k * 17);
      chk(d == e, "R6 first read byte", d, e);
      recv_byte(1'b1, d);
      e = 8'h3C + 8'((k + 1) * 17);
      chk(d == e, "R6 second read byte", d, e);
      chk(sda_bus == 1, "R7 line released after nack", sda_bus, 1);
      #200ns;
      chk(pop_cnt == 2, "R7 no byte taken after nack", pop_cnt, 2);
      chk(nack_cnt == 1, "R7 nack pulse", nack_cnt, 1);
      bus_stop();
      #100ns;
      chk(sel == 0 && rd_mode == 0, "R8 stop clears direction", {sel, rd_mode}, 0);

      // write then repeated START into read
      bus_start();
      send_byte({7'h51, 1'b0}, ack);
      exp_rx.push_back(8'h5A);
      send_byte(8'h5A, ack);
      chk(ack, "R5 byte before repeated start", ack, 1);
      k = tx_k;
      bus_rstart();
      send_byte({7'h51, 1'b1}, ack);
      chk(ack, "R9 repeated start address ack", ack, 1);
      chk(rd_mode == 1, "R9 direction replaced", rd_mode, 1);
      recv_byte(1'b1, d);
      e = 8'h3C + 8'(k * 17);
      chk(d == e, "R9 read after repeated start", d, e);
      bus_stop();
      #100ns;

      // STOP pattern inside the address phase is ignored (address 0x51 = 1010001)
      bus_start();
      begin
         logic s;
         clk_bit(1'b1, s);
         sda_ctl = 1'b0; #Q; scl = 1'b1; #Q; sda_ctl = 1'b1; #Q; scl = 1'b0; #Q;
         clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b0, s);
         clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
         clk_bit(1'b1, s);
         chk(s == 0, "R10 ack despite stop pattern", s, 0);
      end
      chk(sel == 1, "R10 selected", sel, 1);
      bus_stop();
      #100ns;

      // other strap setting: address 0x44
      strap = 3'b010;
      #100ns;
      bus_start();
      send_byte({7'h44, 1'b0}, ack);
      chk(ack, "R2 new strap address ack", ack, 1);
      exp_rx.push_back(8'hC3);
      send_byte(8'hC3, ack);
      bus_stop();
      #100ns;

      chk(exp_rx.size() == 0, "R5 all bytes received", exp_rx.size(), 0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1500us;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule